// File: doc/BRIEF.md
# Transfer Descriptor Status Updater

This block sits between a host controller's descriptor walker and its device-side transaction engine. Once a transaction has finished, the walker hands over the descriptor's control/status word, its token word and the result reported by the device side. The result is a byte count, a stall, a babble, a NAK or a timeout. The block returns the control/status word that should be written back to memory, the interrupt causes to merge into the frame's pending set, the host error flags, and a disposition that tells the walker how to move on: done, skip, pending or fatal.

The decision is combinational. It is captured in one output register behind a valid/ready handshake, so a result appears one clock after the request is accepted. The block also decodes the token word into PID, device address, endpoint and maximum length, and outputs these with the verdict. Descriptor and buffer memory traffic stays with the walker.

Top module: `desc_status_updater`

## Requirements
- R1: While reset is asserted and in the first cycle after it, o_valid is 0. o_in_ready is 1 whenever the output register is empty.
- R2: A request is taken on a clock edge where i_valid and o_in_ready are both 1. Its result is presented with o_valid=1 after that same edge. While o_valid=1 and i_out_ready=0, the outputs hold and o_in_ready is 0.
- R3: If control bit 23 (active) is 0, the disposition is skip (code 1). The control word comes back unchanged and no cause or error flag is raised.
- R4: An active descriptor whose PID (token bits 7:0) is none of 0x2D (setup), 0x69 (in) or 0xE1 (out) gets the fatal disposition (code 3) and raises o_proc_err. Its control word is unchanged.
- R5: A byte-count result (kind 0) writes (len-1) mod 2048 into control bits 10:0 and clears bit 23 (active) and bit 19 (NAK). It gives disposition done (code 0) and raises o_ioc when bit 24 is set.
- R6: Device address is token bits 14:8 and endpoint is token bits 18:15. Maximum length is (token bits 31:21 + 1) mod 2048, so a field of 0x7FF means zero bytes.
- R7: For PID in, a byte count above the maximum length is first written as in R5. Bits 20 (babble) and 22 (stalled) are then set, o_usb_err is raised, o_ioc follows bit 24, and the disposition is skip.
- R8: With bit 29 (short-packet detect) set, a byte count below the maximum raises o_short and gives skip. With bit 29 clear, the same count gives done.
- R9: A stall result (kind 1) sets bit 22. A babble result (kind 2) sets bits 20 and 22. Either one clears active, raises o_usb_err, raises o_ioc when bit 24 is set, and gives skip.
- R10: A NAK result (kind 3) sets bit 19, leaves active set and gives pending (code 2). With PID setup, a NAK is handled as a timeout instead.
- R11: A timeout (kind 4) sets bit 18 and gives skip. A non-zero counter in bits 28:27 is decremented and written back. When it reaches 0, active is cleared, o_usb_err is raised and o_ioc follows bit 24. A counter already at 0 stays 0 and active stays set.
- R12: When bit 25 (isochronous) is set on an active descriptor with a valid PID, active is cleared whatever the result kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | Request present |
| o_in_ready | output | 1 | Request can be taken this cycle |
| i_ctrl | input | 32 | Descriptor control/status word |
| i_token | input | 32 | Descriptor token word |
| i_kind | input | 3 | Result kind: 0 count, 1 stall, 2 babble, 3 NAK, 4 timeout (others act as timeout) |
| i_len | input | LEN_W | Byte count returned by the device side |
| o_valid | output | 1 | Result present |
| i_out_ready | input | 1 | Consumer takes the result |
| o_ctrl | output | 32 | Updated control/status word |
| o_disp | output | 2 | Disposition: 0 done, 1 skip, 2 pending, 3 fatal |
| o_ioc | output | 1 | Completion interrupt cause |
| o_short | output | 1 | Short-packet interrupt cause |
| o_usb_err | output | 1 | Transaction error status |
| o_proc_err | output | 1 | Process error status |
| o_pid | output | 8 | Decoded PID |
| o_dev_addr | output | 7 | Decoded device address |
| o_endpt | output | 4 | Decoded endpoint |
| o_max_len | output | 11 | Decoded maximum length |

## Verification
Every result field passes through the same single output register, so each one is due exactly one clock edge after the edge that accepted the request. The bench drives a request at a falling edge and lets the next rising edge capture it. It then compares every field at the following falling edge against a bench model built from the requirements, and never samples at the capturing edge. In the back-pressure case a second request is held on the inputs while consumer-ready is low. The captured result must stay unchanged at each falling edge, and the held request's result must appear only one edge after consumer-ready returns.

// File: rtl/desc_upd_pkg.sv
package desc_upd_pkg;

   // control/status word bit positions (memory layout, fixed)
   localparam int CB_SPD     = 29;
   localparam int CB_ERR_LO  = 27;
   localparam int CB_ISO     = 25;
   localparam int CB_IOC     = 24;
   localparam int CB_ACT     = 23;
   localparam int CB_STL     = 22;
   localparam int CB_BAB     = 20;
   localparam int CB_NAK     = 19;
   localparam int CB_TMO     = 18;
   localparam int ACTLEN_W   = 11;

   typedef enum logic [1:0] {
      DISP_DONE  = 2'd0,
      DISP_SKIP  = 2'd1,
      DISP_PEND  = 2'd2,
      DISP_FATAL = 2'd3
   } disp_e;

   typedef enum logic [2:0] {
      RES_DATA   = 3'd0,
      RES_STALL  = 3'd1,
      RES_BABBLE = 3'd2,
      RES_NAK    = 3'd3,
      RES_TMO    = 3'd4
   } res_e;

   typedef struct packed {
      logic [7:0]          pid;
      logic [6:0]          addr;
      logic [3:0]          ep;
      logic [ACTLEN_W-1:0] max_len;
   } tok_t;

   typedef struct packed {
      logic [31:0] ctrl;
      disp_e       disp;
      logic        ioc;
      logic        shrt;
      logic        usb_err;
      logic        proc_err;
   } verdict_t;

endpackage

// File: rtl/desc_token_decode.sv
module desc_token_decode
   import desc_upd_pkg::*;
#(
   parameter logic [7:0] PID_SETUP = 8'h2D,
   parameter logic [7:0] PID_IN    = 8'h69,
   parameter logic [7:0] PID_OUT   = 8'hE1
) (
   input  logic [31:0] token,
   output tok_t        tok,
   output logic        pid_ok,
   output logic        is_setup,
   output logic        is_in
);
   localparam int NUM_PID = 3;
   localparam logic [7:0] PID_TAB [NUM_PID] = '{PID_SETUP, PID_IN, PID_OUT};

   logic [NUM_PID-1:0] hit;

   for (genvar g = 0; g < NUM_PID; g++) begin : g_pid
      assign hit[g] = (token[7:0] == PID_TAB[g]);
   end

   assign pid_ok      = |hit;
   assign is_setup    = hit[0];
   assign is_in       = hit[1];
   assign tok.pid     = token[7:0];
   assign tok.addr    = token[14:8];
   assign tok.ep      = token[18:15];
   assign tok.max_len = token[31:21] + 11'd1;
endmodule

// File: rtl/desc_status_core.sv
module desc_status_core
   import desc_upd_pkg::*;
#(
   parameter int LEN_W = 12
) (
   input  logic [31:0]      ctrl,
   input  logic [2:0]       kind,
   input  logic [LEN_W-1:0] len,
   input  tok_t             tok,
   input  logic             pid_ok,
   input  logic             is_setup,
   input  logic             is_in,
   output verdict_t         vd
);
   logic [LEN_W-1:0] max_ext;
   logic             oversize;
   logic             undersize;
   logic [2:0]       kind_eff;
   logic [1:0]       err_cnt;
   logic [1:0]       err_dec;
   logic [ACTLEN_W-1:0] act_len;

   assign max_ext   = LEN_W'(tok.max_len);
   assign oversize  = is_in && (len > max_ext);
   assign undersize = len < max_ext;
   assign kind_eff  = (kind == RES_NAK && is_setup) ? RES_TMO : kind;
   assign err_cnt   = ctrl[CB_ERR_LO+1:CB_ERR_LO];
   assign err_dec   = err_cnt - 2'd1;
   assign act_len   = len[ACTLEN_W-1:0] - 11'd1;

   always_comb begin
      vd          = '0;
      vd.ctrl     = ctrl;
      vd.disp     = DISP_SKIP;
      if (!ctrl[CB_ACT]) begin
         vd.disp = DISP_SKIP;
      end else if (!pid_ok) begin
         vd.disp     = DISP_FATAL;
         vd.proc_err = 1'b1;
      end else begin
         if (ctrl[CB_ISO])
            vd.ctrl[CB_ACT] = 1'b0;
         case (kind_eff)
            RES_DATA: begin
               vd.ctrl[ACTLEN_W-1:0] = act_len;
               vd.ctrl[CB_ACT]       = 1'b0;
               vd.ctrl[CB_NAK]       = 1'b0;
               vd.ioc                = ctrl[CB_IOC];
               if (oversize) begin
                  vd.ctrl[CB_BAB] = 1'b1;
                  vd.ctrl[CB_STL] = 1'b1;
                  vd.usb_err      = 1'b1;
                  vd.disp         = DISP_SKIP;
               end else if (ctrl[CB_SPD] && undersize) begin
                  vd.shrt = 1'b1;
                  vd.disp = DISP_SKIP;
               end else begin
                  vd.disp = DISP_DONE;
               end
            end
            RES_STALL, RES_BABBLE: begin
               vd.ctrl[CB_STL] = 1'b1;
               if (kind_eff == RES_BABBLE)
                  vd.ctrl[CB_BAB] = 1'b1;
               vd.ctrl[CB_ACT] = 1'b0;
               vd.usb_err      = 1'b1;
               vd.ioc          = ctrl[CB_IOC];
               vd.disp         = DISP_SKIP;
            end
            RES_NAK: begin
               vd.ctrl[CB_NAK] = 1'b1;
               vd.disp         = DISP_PEND;
            end
            default: begin
               vd.ctrl[CB_TMO] = 1'b1;
               vd.disp         = DISP_SKIP;
               if (err_cnt != 2'd0) begin
                  vd.ctrl[CB_ERR_LO+1:CB_ERR_LO] = err_dec;
                  if (err_dec == 2'd0) begin
                     vd.ctrl[CB_ACT] = 1'b0;
                     vd.usb_err      = 1'b1;
                     vd.ioc          = ctrl[CB_IOC];
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/desc_out_stage.sv
module desc_out_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   logic         vld_q;
   logic [W-1:0] dat_q;
   logic         take;

   assign in_ready  = !vld_q || out_ready;
   assign take      = in_valid && in_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
      end else if (take) begin
         vld_q <= 1'b1;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         dat_q <= '0;
      else if (take)
         dat_q <= in_data;
   end
endmodule

// File: rtl/desc_status_updater.sv
module desc_status_updater
   import desc_upd_pkg::*;
#(
   parameter int         LEN_W     = 12,
   parameter logic [7:0] PID_SETUP = 8'h2D,
   parameter logic [7:0] PID_IN    = 8'h69,
   parameter logic [7:0] PID_OUT   = 8'hE1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             i_valid,
   output logic             o_in_ready,
   input  logic [31:0]      i_ctrl,
   input  logic [31:0]      i_token,
   input  logic [2:0]       i_kind,
   input  logic [LEN_W-1:0] i_len,
   output logic             o_valid,
   input  logic             i_out_ready,
   output logic [31:0]      o_ctrl,
   output logic [1:0]       o_disp,
   output logic             o_ioc,
   output logic             o_short,
   output logic             o_usb_err,
   output logic             o_proc_err,
   output logic [7:0]       o_pid,
   output logic [6:0]       o_dev_addr,
   output logic [3:0]       o_endpt,
   output logic [10:0]      o_max_len
);
   localparam int PAY_W = $bits(verdict_t) + $bits(tok_t);

   if (LEN_W < ACTLEN_W + 1) begin : g_len_chk
      $error("LEN_W must hold counts above the largest maximum length");
   end
   if (PID_SETUP == PID_IN || PID_IN == PID_OUT || PID_SETUP == PID_OUT) begin : g_pid_chk
      $error("PID codes must be distinct");
   end

   tok_t     tok;
   verdict_t vd;
   logic     pid_ok, is_setup, is_in;
   tok_t     tok_q;
   verdict_t vd_q;

   desc_token_decode #(
      .PID_SETUP (PID_SETUP),
      .PID_IN    (PID_IN),
      .PID_OUT   (PID_OUT)
   ) dec_i (
      .token    (i_token),
      .tok      (tok),
      .pid_ok   (pid_ok),
      .is_setup (is_setup),
      .is_in    (is_in)
   );

   desc_status_core #(.LEN_W(LEN_W)) core_i (
      .ctrl     (i_ctrl),
      .kind     (i_kind),
      .len      (i_len),
      .tok      (tok),
      .pid_ok   (pid_ok),
      .is_setup (is_setup),
      .is_in    (is_in),
      .vd       (vd)
   );

   desc_out_stage #(.W(PAY_W)) out_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (i_valid),
      .in_ready  (o_in_ready),
      .in_data   ({vd, tok}),
      .out_valid (o_valid),
      .out_ready (i_out_ready),
      .out_data  ({vd_q, tok_q})
   );

   assign o_ctrl     = vd_q.ctrl;
   assign o_disp     = vd_q.disp;
   assign o_ioc      = vd_q.ioc;
   assign o_short    = vd_q.shrt;
   assign o_usb_err  = vd_q.usb_err;
   assign o_proc_err = vd_q.proc_err;
   assign o_pid      = tok_q.pid;
   assign o_dev_addr = tok_q.addr;
   assign o_endpt    = tok_q.ep;
   assign o_max_len  = tok_q.max_len;
endmodule

// File: rtl/desc_status_updater_chk.sv
module desc_status_updater_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        o_valid,
   input logic        i_out_ready,
   input logic        o_in_ready,
   input logic [31:0] o_ctrl,
   input logic [1:0]  o_disp,
   input logic        o_ioc,
   input logic        o_short,
   input logic        o_usb_err,
   input logic        o_proc_err
);
   p_idle_after_reset_r1: assert property (@(posedge clk)
      !rst_n |=> !o_valid);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !i_out_ready) |=> (o_valid && $stable(o_ctrl) && $stable(o_disp)
                                     && $stable(o_ioc) && $stable(o_usb_err)));

   p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !i_out_ready) |-> !o_in_ready);

   p_fatal_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_disp == 2'd3) |-> o_proc_err);

   p_proc_only_fatal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_proc_err) |-> (o_disp == 2'd3 && !o_usb_err));

   p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_disp == 2'd0) |-> (!o_ctrl[23] && !o_ctrl[19] && !o_short));

   p_usb_err_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_usb_err) |-> !o_ctrl[23]);

   p_pending_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && o_disp == 2'd2 && !o_ctrl[25]) |-> (o_ctrl[23] && o_ctrl[19]));
endmodule

bind desc_status_updater desc_status_updater_chk chk_i (.*);

// File: tb/desc_status_updater_tb_top.sv
`timescale 1ns/1ps
module desc_status_updater_tb_top;
   localparam int LEN_W = 12;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             i_valid, o_in_ready, o_valid, i_out_ready;
   logic [31:0]      i_ctrl, i_token, o_ctrl;
   logic [2:0]       i_kind;
   logic [LEN_W-1:0] i_len;
   logic [1:0]       o_disp;
   logic             o_ioc, o_short, o_usb_err, o_proc_err;
   logic [7:0]       o_pid;
   logic [6:0]       o_dev_addr;
   logic [3:0]       o_endpt;
   logic [10:0]      o_max_len;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   desc_status_updater #(.LEN_W(LEN_W)) dut_i (.*);

   localparam logic [31:0] ACT = 32'h0080_0000, IOC = 32'h0100_0000,
                           SPD = 32'h2000_0000, ISO = 32'h0200_0000,
                           NAKB = 32'h0008_0000;

   function automatic logic [31:0] mk_tok(input logic [10:0] mf, input logic [3:0] ep,
                                          input logic [6:0] ad, input logic [7:0] pid);
      return {mf, 2'b00, ep, ad, pid};
   endfunction

   // expected behaviour from the requirements
   task automatic model(input logic [31:0] c, input logic [31:0] t, input logic [2:0] k,
                        input logic [LEN_W-1:0] l, output logic [31:0] nc, output logic [1:0] d,
                        output logic ioc, output logic sh, output logic ue, output logic pe);
      logic [10:0] mx;
      logic [2:0]  ke;
      logic [1:0]  e;
      logic        ok;
      mx = t[31:21] + 11'd1;
      ok = (t[7:0] == 8'h2D) || (t[7:0] == 8'h69) || (t[7:0] == 8'hE1);
      nc = c; d = 2'd1; ioc = 0; sh = 0; ue = 0; pe = 0;
      if (!c[23]) begin
         d = 2'd1;
      end else if (!ok) begin
         d = 2'd3; pe = 1;
      end else begin
         if (c[25]) nc[23] = 0;
         ke = (k == 3'd3 && t[7:0] == 8'h2D) ? 3'd4 : k;
         if (ke == 3'd0) begin
            nc[10:0] = l[10:0] - 11'd1;
            nc[23] = 0; nc[19] = 0; ioc = c[24];
            if (t[7:0] == 8'h69 && l > {1'b0, mx}) begin
               nc[20] = 1; nc[22] = 1; ue = 1; d = 2'd1;
            end else if (c[29] && l < {1'b0, mx}) begin
               sh = 1; d = 2'd1;
            end else d = 2'd0;
         end else if (ke == 3'd1 || ke == 3'd2) begin
            nc[22] = 1; if (ke == 3'd2) nc[20] = 1;
            nc[23] = 0; ue = 1; ioc = c[24]; d = 2'd1;
         end else if (ke == 3'd3) begin
            nc[19] = 1; d = 2'd2;
         end else begin
            nc[18] = 1; d = 2'd1;
            e = c[28:27];
            if (e != 0) begin
               e = e - 2'd1; nc[28:27] = e;
               if (e == 0) begin nc[23] = 0; ue = 1; ioc = c[24]; end
            end
         end
      end
   endtask

   task automatic check_out(input string tag, input logic [31:0] c, input logic [31:0] t,
                            input logic [2:0] k, input logic [LEN_W-1:0] l);
      logic [31:0] nc; logic [1:0] d; logic ioc, sh, ue, pe;
      logic [10:0] mx;
      model(c, t, k, l, nc, d, ioc, sh, ue, pe);
      mx = t[31:21] + 11'd1;
      n_checks++;
      if (!(o_valid === 1'b1 && o_ctrl === nc && o_disp === d && o_ioc === ioc &&
            o_short === sh && o_usb_err === ue && o_proc_err === pe)) begin
         n_errs++;
         $display("FAIL %s: got v=%b ctrl=%h disp=%0d ioc=%b sh=%b ue=%b pe=%b exp v=1 ctrl=%h disp=%0d ioc=%b sh=%b ue=%b pe=%b",
                  tag, o_valid, o_ctrl, o_disp, o_ioc, o_short, o_usb_err, o_proc_err,
                  nc, d, ioc, sh, ue, pe);
      end
      n_checks++;
      if (!(o_pid === t[7:0] && o_dev_addr === t[14:8] && o_endpt === t[18:15] &&
            o_max_len === mx)) begin
         n_errs++;
         $display("FAIL R6: got pid=%h ad=%h ep=%h mx=%h exp pid=%h ad=%h ep=%h mx=%h",
                  o_pid, o_dev_addr, o_endpt, o_max_len, t[7:0], t[14:8], t[18:15], mx);
      end
   endtask

   task automatic send(input string tag, input logic [31:0] c, input logic [31:0] t,
                       input logic [2:0] k, input logic [LEN_W-1:0] l);
      @(negedge clk);
      i_ctrl = c; i_token = t; i_kind = k; i_len = l;
      i_valid = 1; i_out_ready = 1;
      @(posedge clk);
      @(negedge clk);
      i_valid = 0;
      check_out(tag, c, t, k, l);
   endtask

   function automatic string classify(input logic [31:0] c, input logic [31:0] t,
                                      input logic [2:0] k, input logic [LEN_W-1:0] l);
      logic [10:0] mx;
      mx = t[31:21] + 11'd1;
      if (!c[23]) return "R3";
      if (!(t[7:0] == 8'h2D || t[7:0] == 8'h69 || t[7:0] == 8'hE1)) return "R4";
      if (c[25]) return "R12";
      if (k == 3'd0) begin
         if (t[7:0] == 8'h69 && l > {1'b0, mx}) return "R7";
         if (c[29] && l < {1'b0, mx}) return "R8";
         return "R5";
      end
      if (k == 3'd1 || k == 3'd2) return "R9";
      if (k == 3'd3) return "R10";
      return "R11";
   endfunction

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog: got hang exp completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed_dummy;
      logic [31:0] tA, tB, cA, cB;
      rst_n = 0; i_valid = 0; i_out_ready = 1;
      i_ctrl = 0; i_token = 0; i_kind = 0; i_len = 0;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (o_valid !== 1'b0 || o_in_ready !== 1'b1) begin
         n_errs++;
         $display("FAIL R1: got v=%b rdy=%b exp v=0 rdy=1", o_valid, o_in_ready);
      end
      rst_n = 1;
      @(negedge clk);
      n_checks++;
      if (o_valid !== 1'b0) begin
         n_errs++;
         $display("FAIL R1: got v=%b exp v=0 after reset", o_valid);
      end

      // directed corners
      send("R3",  32'h1100_0005 & ~ACT, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd0, 12'd4);
      send("R4",  ACT | IOC,            mk_tok(11'd7, 4'd1, 7'd3, 8'h55), 3'd0, 12'd4);
      send("R5",  ACT | IOC | 32'h1800_0000, mk_tok(11'd7, 4'd2, 7'd9, 8'h69), 3'd0, 12'd8);
      send("R5",  ACT | NAKB | 32'h0000_0123, mk_tok(11'd63, 4'd0, 7'd0, 8'hE1), 3'd0, 12'd20);
      send("R6",  ACT, mk_tok(11'h7FF, 4'hF, 7'h7F, 8'hE1), 3'd0, 12'd0);
      send("R7",  ACT | IOC, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd0, 12'd9);
      send("R8",  ACT | SPD | IOC, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd0, 12'd3);
      send("R8",  ACT, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd0, 12'd3);
      send("R9",  ACT | IOC, mk_tok(11'd7, 4'd1, 7'd3, 8'hE1), 3'd1, 12'd0);
      send("R9",  ACT, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd2, 12'd0);
      send("R10", ACT | 32'h1800_0000, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd3, 12'd0);
      send("R10", ACT | 32'h1800_0000, mk_tok(11'd7, 4'd1, 7'd3, 8'h2D), 3'd3, 12'd0);
      send("R11", ACT | IOC | 32'h0800_0000, mk_tok(11'd7, 4'd1, 7'd3, 8'hE1), 3'd4, 12'd0);
      send("R11", ACT | IOC, mk_tok(11'd7, 4'd1, 7'd3, 8'hE1), 3'd4, 12'd0);
      send("R12", ACT | ISO, mk_tok(11'd7, 4'd1, 7'd3, 8'h69), 3'd3, 12'd0);

      // back-pressure
      cA = ACT | IOC; tA = mk_tok(11'd15, 4'd3, 7'd5, 8'h69);
      cB = ACT;       tB = mk_tok(11'd3, 4'd4, 7'd6, 8'hE1);
      @(negedge clk);
      i_ctrl = cA; i_token = tA; i_kind = 3'd0; i_len = 12'd16; i_valid = 1; i_out_ready = 1;
      @(posedge clk);
      @(negedge clk);
      i_ctrl = cB; i_token = tB; i_kind = 3'd1; i_len = 12'd0; i_valid = 1; i_out_ready = 0;
      for (int w = 0; w < 3; w++) begin
         @(posedge clk);
         @(negedge clk);
         check_out("R2", cA, tA, 3'd0, 12'd16);
         n_checks++;
         if (o_in_ready !== 1'b0) begin
            n_errs++;
            $display("FAIL R2: got rdy=%b exp rdy=0", o_in_ready);
         end
      end
      i_out_ready = 1;
      @(posedge clk);
      @(negedge clk);
      i_valid = 0;
      check_out("R2", cB, tB, 3'd1, 12'd0);

      // constrained random
      for (int n = 0; n < 400; n++) begin
         logic [31:0] c, t;
         logic [2:0]  k;
         logic [LEN_W-1:0] l;
         logic [7:0]  pid;
         logic [10:0] mf;
         int sel;
         c = $urandom();
         c[23] = ($urandom_range(0, 9) < 8);
         c[25] = ($urandom_range(0, 9) < 2);
         sel = $urandom_range(0, 9);
         pid = (sel < 3) ? 8'h2D : (sel < 6) ? 8'h69 : (sel < 9) ? 8'hE1 : 8'($urandom());
         mf = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : 11'($urandom_range(0, 70));
         t = mk_tok(mf, 4'($urandom()), 7'($urandom()), pid);
         k = 3'($urandom_range(0, 4));
         l = ($urandom_range(0, 3) == 0) ? 12'($urandom_range(0, 2048))
                                         : 12'(32'(mf) + 1 + 32'($urandom_range(0, 4)) - 2);
         send(classify(c, t, k, l), c, t, k, l);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule